// File: doc/BRIEF.md
# I/O Page Table Translator

This block converts a device's DMA virtual address into a 36-bit physical address. It does this with a single-level lookup in a page table held in system memory. A request carries an address and a read/write flag. The translator forms the address of the table entry from the table base value and the start of the mapped window, then issues one 32-bit read on its memory port. When the entry returns, it checks the entry's valid and writable bits. It then answers with either a translated address and a permission level, or a fault.

On a fault, the translator pulses a write strobe toward the register block with a fixed status pattern and the page-aligned faulting address, and pulses an interrupt-set line. Nothing is cached: every request performs a fresh table read, so no invalidation is needed. Request, memory read and response each use a valid/ready style handshake. Only one lookup is in flight at a time.

Top module: `iopt_walker`

## Requirements
- R1: `reqReady` is high only when no lookup is in progress. A new request is accepted only after the previous response has been taken.
- R2: The entry read address is `{tblBase, 4'h0} + ((((reqAddr & ~32'hFFF) & ~windowStart) >> 10) & ~3)`, which is 36 bits wide.
- R3: `memReqValid` stays high with `memReqAddr` unchanged until `memReqReady` is seen.
- R4: On success, `rspAddr` is `{entry[31:8], reqAddr[11:0]}`. Entry bits 31:8 hold physical address bits 35:12, and `memRspData` holds the big-endian word with the lowest-addressed byte in bits 31:24.
- R5: An entry whose valid bit (bit 1) is clear gives a fault response: `rspErr`=1, `rspPerm`=2'b00, `rspAddr`=0, `rspMask` all ones.
- R6: A write request to a valid entry whose writable bit (bit 2) is clear faults. A read request to the same entry succeeds.
- R7: A successful response carries `rspPerm`=2'b11 (read-write) when bit 2 is set and 2'b01 (read-only) otherwise, with `rspMask`=36'hFFF and `rspErr`=0.
- R8: On a fault, `faultWe` and `irqSet` pulse high for exactly the first cycle of the response. `faultStatus` is 32'hC0820000, ORed with 32'h00040000 for a read, and `faultAddr` is the request address with bits 11:0 cleared.
- R9: A successful translation produces no `faultWe` or `irqSet` pulse.
- R10: `rspValid` stays high with every response field unchanged until `rspReady` is seen.
- R11: Every request, including a repeat of an earlier address, issues its own memory read.
- R12: After reset, `reqReady`=1 and `memReqValid`, `rspValid`, `faultWe` and `irqSet` are 0. This also holds when reset strikes in the middle of a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tblBase | input | 32 | Page table base value, scaled by 16 to form a byte address |
| windowStart | input | 32 | Start of the mapped DMA window; its set bits are masked out of the address |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Translator can accept a request |
| reqAddr | input | 32 | DMA virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory accepts the entry read |
| memReqAddr | output | 36 | Byte address of the table entry |
| memRspValid | input | 1 | Entry data valid |
| memRspData | input | 32 | Entry word, big-endian byte order |
| rspValid | output | 1 | Translation response valid |
| rspReady | input | 1 | Requester takes the response |
| rspAddr | output | 36 | Physical address, zero on fault |
| rspPerm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rspMask | output | 36 | Low-bit mask of the mapping: 12'hFFF, all ones on fault |
| rspErr | output | 1 | Translation faulted |
| faultWe | output | 1 | One-cycle strobe to load fault status and address |
| faultStatus | output | 32 | Fault status value to store |
| faultAddr | output | 32 | Page-aligned faulting address to store |
| irqSet | output | 1 | One-cycle pulse to raise the interrupt |

## Verification
The assertions assume that the memory side sends `memRspValid` only while the translator waits for the entry, and only once for each accepted read. The bench model returns exactly one word, one cycle after each accepted read. The assertions also assume that `tblBase` and `windowStart` do not change while a request is being accepted. The bench changes them only between lookups, while the translator is idle. Handshake stalls on the memory and response sides are varied per vector, so the hold rules are exercised both with and without back-pressure.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CHECK
  } walkState_t;

  typedef struct packed {
    logic loadReq;    // capture request and form entry address
    logic loadEntry;  // capture returned table entry
  } walkStrobe_t;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b11;

  localparam int PTE_VALID_BIT = 1;
  localparam int PTE_WRITE_BIT = 2;

  localparam logic [31:0] FAULT_STATUS_BASE = 32'hC082_0000;
  localparam logic [31:0] FAULT_STATUS_READ = 32'h0004_0000;

endpackage

// File: rtl/iopt_ctrl.sv
module iopt_ctrl
  import iopt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output walkStrobe_t strobe
);

  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid)    stateNext = ST_ISSUE;
      ST_ISSUE: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_CHECK;
      ST_CHECK: if (rspReady)    stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  assign reqReady         = (state == ST_IDLE);
  assign memReqValid      = (state == ST_ISSUE);
  assign rspValid         = (state == ST_CHECK);
  assign strobe.loadReq   = (state == ST_IDLE) && reqValid;
  assign strobe.loadEntry = (state == ST_WAIT) && memRspValid;

  p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (!memReqValid && !rspValid));

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> memReqValid);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspReady) |=> rspValid);

  p_fresh_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadReq |=> memReqValid);

endmodule

// File: rtl/iopt_datapath.sv
module iopt_datapath
  import iopt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   tblBase,
  input  logic [VA_W-1:0]   windowStart,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqWrite,
  input  logic [31:0]       memRspData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   rspAddr,
  output logic [1:0]        rspPerm,
  output logic [PA_W-1:0]   rspMask,
  output logic              rspErr,
  output logic              faultWe,
  output logic [31:0]       faultStatus,
  output logic [VA_W-1:0]   faultAddr
);

  localparam int OFF_W       = PAGE_SHIFT;
  localparam int PPN_W       = PA_W - PAGE_SHIFT;
  localparam int ENTRY_SHIFT = PAGE_SHIFT - 2;
  localparam int BASE_SHIFT  = PA_W - VA_W;

  logic [VA_W-1:0]  curAddr;
  logic             curWrite;
  logic [PA_W-1:0]  entryAddrReg;
  logic [PPN_W-1:0] entryPpn;
  logic             entryValid;
  logic             entryWrite;
  logic             faultPulse;

  logic [VA_W-1:0]  reqPage;
  logic [VA_W-1:0]  tblOffset;
  logic [PA_W-1:0]  entryAddrNext;
  logic             incomingFault;
  logic             isFault;
  logic             unusedEntryBits;

  assign reqPage       = {reqAddr[VA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign tblOffset     = ((reqPage & ~windowStart) >> ENTRY_SHIFT) & ~VA_W'(3);
  assign entryAddrNext = {tblBase, {BASE_SHIFT{1'b0}}} + PA_W'(tblOffset);

  assign incomingFault = !memRspData[PTE_VALID_BIT] ||
                         (curWrite && !memRspData[PTE_WRITE_BIT]);
  assign unusedEntryBits = ^{memRspData[7:3], memRspData[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr      <= '0;
      curWrite     <= 1'b0;
      entryAddrReg <= '0;
      entryPpn     <= '0;
      entryValid   <= 1'b0;
      entryWrite   <= 1'b0;
      faultPulse   <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        curAddr      <= reqAddr;
        curWrite     <= reqWrite;
        entryAddrReg <= entryAddrNext;
      end
      if (strobe.loadEntry) begin
        entryPpn   <= memRspData[31 -: PPN_W];
        entryValid <= memRspData[PTE_VALID_BIT];
        entryWrite <= memRspData[PTE_WRITE_BIT];
      end
      faultPulse <= strobe.loadEntry && incomingFault;
    end
  end

  assign memReqAddr = entryAddrReg;
  assign isFault    = !entryValid || (curWrite && !entryWrite);

  always_comb begin
    if (isFault) begin
      rspAddr = '0;
      rspPerm = PERM_NONE;
      rspMask = '1;
    end else begin
      rspAddr = {entryPpn, curAddr[OFF_W-1:0]};
      rspPerm = entryWrite ? PERM_RW : PERM_RO;
      rspMask = PA_W'({OFF_W{1'b1}});
    end
  end

  assign rspErr      = isFault;
  assign faultWe     = faultPulse;
  assign faultStatus = FAULT_STATUS_BASE | (curWrite ? 32'h0 : FAULT_STATUS_READ);
  assign faultAddr   = {curAddr[VA_W-1:OFF_W], {OFF_W{1'b0}}};

  p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    faultWe |=> !faultWe);

  p_entry_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    faultWe |-> isFault);

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 36,
  parameter int PAGE_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] tblBase,
  input  logic [VA_W-1:0] windowStart,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqAddr,
  input  logic            reqWrite,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [PA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [31:0]     memRspData,
  output logic            rspValid,
  input  logic            rspReady,
  output logic [PA_W-1:0] rspAddr,
  output logic [1:0]      rspPerm,
  output logic [PA_W-1:0] rspMask,
  output logic            rspErr,
  output logic            faultWe,
  output logic [31:0]     faultStatus,
  output logic [VA_W-1:0] faultAddr,
  output logic            irqSet
);

  walkStrobe_t strobe;

  iopt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspReady    (rspReady),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  iopt_datapath #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .tblBase     (tblBase),
    .windowStart (windowStart),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspAddr     (rspAddr),
    .rspPerm     (rspPerm),
    .rspMask     (rspMask),
    .rspErr      (rspErr),
    .faultWe     (faultWe),
    .faultStatus (faultStatus),
    .faultAddr   (faultAddr)
  );

  assign irqSet = faultWe;

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

  p_fault_in_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    faultWe |-> (rspValid && rspErr));

  p_fault_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspErr) |-> (rspPerm == PERM_NONE && rspAddr == '0));

  p_ok_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspErr) |-> (rspPerm != PERM_NONE && !faultWe));

  p_rsp_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspReady) |=> ($stable(rspAddr) && $stable(rspPerm) && $stable(rspErr)));

endmodule

// File: tb/tb_iopt_walker.sv
module tb_iopt_walker;

  typedef struct packed {
    logic [31:0] addr;
    logic        write;
    logic [31:0] base;
    logic [31:0] window;
    logic [31:0] entry;
    logic [3:0]  memDelay;
    logic [3:0]  rspDelay;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFF01_2345, 1'b0, 32'h0001_0000, 32'hFF00_0000, 32'h1234_5606, 4'd0, 4'd0}, // RW read
    '{32'hFE7F_F010, 1'b1, 32'h0000_4400, 32'hFE00_0000, 32'hABCD_EF86, 4'd2, 4'd3}, // RW write
    '{32'hF000_0ABC, 1'b0, 32'h0040_0000, 32'hF000_0000, 32'h0000_0102, 4'd1, 4'd0}, // RO read
    '{32'hF000_0ABC, 1'b1, 32'h0040_0000, 32'hF000_0000, 32'h0000_0102, 4'd0, 4'd2}, // RO write fault
    '{32'hC123_4567, 1'b0, 32'h0007_FC00, 32'hC000_0000, 32'hFFFF_FF04, 4'd3, 4'd1}, // invalid read
    '{32'hC123_4567, 1'b1, 32'h0007_FC00, 32'hC000_0000, 32'h0000_0000, 4'd0, 4'd0}, // invalid write
    '{32'hFFFF_FFFF, 1'b0, 32'h07FF_FC00, 32'h8000_0000, 32'hFFFF_FF03, 4'd0, 4'd0}, // top page
    '{32'hFF01_2345, 1'b0, 32'h0001_0000, 32'hFF00_0000, 32'h1234_5606, 4'd1, 4'd0}, // repeat
    '{32'hFF01_2FFF, 1'b1, 32'h0001_0000, 32'hFF00_0000, 32'h0000_0087, 4'd0, 4'd1}  // cache+waz
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tblBase = '0;
  logic [31:0] windowStart = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [35:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [35:0] rspAddr;
  logic [1:0]  rspPerm;
  logic [35:0] rspMask;
  logic        rspErr;
  logic        faultWe;
  logic [31:0] faultStatus;
  logic [31:0] faultAddr;
  logic        irqSet;

  int checks = 0;
  int failures = 0;
  int memIssues = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iopt_walker dut (
    .clk(clk), .rst_n(rst_n), .tblBase(tblBase), .windowStart(windowStart),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspAddr(rspAddr), .rspPerm(rspPerm),
    .rspMask(rspMask), .rspErr(rspErr), .faultWe(faultWe), .faultStatus(faultStatus),
    .faultAddr(faultAddr), .irqSet(irqSet)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memReqValid && memReqReady) memIssues <= memIssues + 1;
    if (cycles == 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected fewer)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] expEntryAddr(input vec_t v);
    logic [31:0] pg;
    logic [31:0] off;
    pg  = {v.addr[31:12], 12'h000};
    off = ((pg & ~v.window) >> 10) & ~32'd3;
    return {v.base, 4'h0} + {4'h0, off};
  endfunction

  task automatic runVec(input vec_t v, input int idx);
    bit          flt;
    logic [35:0] expPa;
    logic [1:0]  expPerm;
    logic [31:0] expStat;
    int          issuesBefore;
    flt     = !v.entry[1] || (v.write && !v.entry[2]);
    expPa   = flt ? 36'h0 : {v.entry[31:8], v.addr[11:0]};
    expPerm = flt ? 2'b00 : (v.entry[2] ? 2'b11 : 2'b01);
    expStat = 32'hC082_0000 | (v.write ? 32'h0 : 32'h0004_0000);
    issuesBefore = memIssues;

    @(negedge clk);
    tblBase = v.base; windowStart = v.window;
    reqAddr = v.addr; reqWrite = v.write; reqValid = 1'b1;
    chk(reqReady == 1'b1, $sformatf("R1 vec%0d idle ready", idx), 64'(reqReady), 64'd1);
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'h5A5A_5A5A;
    chk(reqReady == 1'b0, $sformatf("R1 vec%0d busy not ready", idx), 64'(reqReady), 64'd0);
    chk(memReqValid == 1'b1, $sformatf("R11 vec%0d read issued", idx), 64'(memReqValid), 64'd1);
    chk(memReqAddr == expEntryAddr(v), $sformatf("R2 vec%0d entry addr", idx),
        64'(memReqAddr), 64'(expEntryAddr(v)));
    for (int i = 0; i < int'(v.memDelay); i++) begin
      @(negedge clk);
      chk(memReqValid && memReqAddr == expEntryAddr(v), $sformatf("R3 vec%0d hold", idx),
          64'(memReqAddr), 64'(expEntryAddr(v)));
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    memRspValid = 1'b1; memRspData = v.entry;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = 32'hDEAD_BEEF;
    chk(memIssues == issuesBefore + 1, $sformatf("R11 vec%0d one read", idx),
        64'(memIssues - issuesBefore), 64'd1);
    chk(rspValid == 1'b1, $sformatf("R10 vec%0d rsp valid", idx), 64'(rspValid), 64'd1);
    chk(rspErr == flt, $sformatf("%s vec%0d err", flt ? "R5" : "R6", idx), 64'(rspErr), 64'(flt));
    chk(rspAddr == expPa, $sformatf("R4 vec%0d addr", idx), 64'(rspAddr), 64'(expPa));
    chk(rspPerm == expPerm, $sformatf("R7 vec%0d perm", idx), 64'(rspPerm), 64'(expPerm));
    chk(rspMask == (flt ? 36'hF_FFFF_FFFF : 36'hFFF), $sformatf("R7 vec%0d mask", idx),
        64'(rspMask), flt ? 64'hF_FFFF_FFFF : 64'hFFF);
    if (flt) begin
      chk(faultWe && irqSet, $sformatf("R8 vec%0d fault pulse", idx), 64'({faultWe, irqSet}), 64'd3);
      chk(faultStatus == expStat, $sformatf("R8 vec%0d status", idx), 64'(faultStatus), 64'(expStat));
      chk(faultAddr == {v.addr[31:12], 12'h0}, $sformatf("R8 vec%0d fault addr", idx),
          64'(faultAddr), 64'({v.addr[31:12], 12'h0}));
    end else begin
      chk(!faultWe && !irqSet, $sformatf("R9 vec%0d no fault pulse", idx),
          64'({faultWe, irqSet}), 64'd0);
    end
    for (int i = 0; i < int'(v.rspDelay); i++) begin
      @(negedge clk);
      chk(rspValid && rspAddr == expPa && rspPerm == expPerm && rspErr == flt,
          $sformatf("R10 vec%0d hold", idx), 64'(rspAddr), 64'(expPa));
      chk(!faultWe && !irqSet, $sformatf("R8 vec%0d single pulse", idx),
          64'({faultWe, irqSet}), 64'd0);
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(!rspValid && reqReady, $sformatf("R1 vec%0d back to idle", idx),
        64'({rspValid, reqReady}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(reqReady && !memReqValid && !rspValid && !faultWe && !irqSet, "R12 reset state",
        64'({reqReady, memReqValid, rspValid, faultWe, irqSet}), 64'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReqValid, "R12 idle after release", 64'({reqReady, memReqValid}), 64'b10);

    for (int n = 0; n < NVEC; n++) runVec(VECS[n], n);

    // R12: reset in the middle of a lookup returns to idle
    @(negedge clk);
    reqAddr = 32'hFF00_1000; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(reqReady && !memReqValid && !rspValid && !faultWe, "R12 mid-lookup reset",
        64'({reqReady, memReqValid, rspValid, faultWe}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady && !rspValid, "R12 idle after mid reset", 64'({reqReady, rspValid}), 64'b10);

    // After recovery the walker still translates correctly
    runVec(VECS[2], 99);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule